// File: doc/BRIEF.md
# Two-wire online activation code checker

This block sits behind the escape detector of a two-wire to four-wire debug adapter. Once an online escape has been recognised, the detector pulses `start`. The checker then gathers the next twelve control bits from the shared data/mode wire. Each bit is taken on a clock cycle in which the synchronised clock-rise event `tck_rise` is high. The bits form three four-bit fields: an activation code, an extension code and a check packet. Each field is sent least significant bit first.

After the twelfth bit the collected word is compared with the single supported pattern. This pattern selects the star-2 topology and the short form that parks in Run-Test/Idle, and carries an all-zero check packet. On a match the `active` flag rises at the clock edge that takes the last bit. It stays high until an offline request (`cancel`) or reset. On any mismatch, or when `cancel` arrives mid-collection, the checker drops back to offline and emits a one-cycle `abort` pulse. The block runs on a fast system clock; both wire signals arrive already synchronised as event strobes and sampled levels.

Top module: `online_act_checker`

## Requirements
- R1: A synchronous active-high `rst` forces the offline state. While and after it is held, `active` and `abort` are 0.
- R2: While offline, `tck_rise` and `tms_bit` have no effect until `start` is seen. Twelve correct bits sent without `start` leave `active` at 0 and raise no `abort`.
- R3: After `start`, one bit is captured per clock cycle in which `tck_rise` is 1, and exactly twelve are taken. Idle cycles between clock-rise events neither advance nor disturb the collection.
- R4: The accepted wire order, first to last, is 0,0,1,1 (activation code 4'b1100 sent bit 0 first), then 0,0,0,1 (extension code 4'b1000), then 0,0,0,0 (check packet 4'b0000).
- R5: With the correct pattern, `active` stays 0 through the first eleven bits. It reads 1 in the clock cycle right after the edge that captures the twelfth bit.
- R6: If any of the twelve bits differs from the accepted order, the block returns offline after the twelfth bit with `active` at 0. It pulses `abort` high for exactly one cycle, and no `abort` appears before the twelfth bit.
- R7: `cancel` during collection aborts it with a one-cycle `abort` pulse and clears the bit count. Further bits without a new `start` do not activate the block.
- R8: A `start` during collection restarts the count from zero without an `abort`. The block then needs twelve fresh bits to activate.
- R9: While active, `tck_rise`, `tms_bit` and `start` are ignored and `active` stays 1.
- R10: `cancel` or `rst` while active clears `active` in the next cycle without an `abort` pulse.
- R11: `rst` during collection returns to offline without an `abort` pulse, and the remaining bits do not activate the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_rise | input | 1 | One-cycle event: clock wire rose |
| tms_bit | input | 1 | Sampled level of the data/mode wire |
| start | input | 1 | Online escape seen, begin collection |
| cancel | input | 1 | Offline or reset escape seen |
| active | output | 1 | Adapter online, scan format in force |
| abort | output | 1 | One-cycle pulse: activation abandoned |

## Verification
The bench builds the checker with its default parameters: four-bit fields, three fields, and the package's star-2 short-form pattern. This makes the whole twelve-bit window and every field boundary reachable with short directed sequences. Bits are sent both back to back and with idle gaps, so counting is tied to clock-rise events and not to system clock cycles. Errors are placed in the first and in the last field, to show that the abort waits for the final bit. Restart, cancel and reset are each applied part-way through a sequence, so their effect on the count is seen at the ports.

// File: rtl/oac_pkg.sv
package oac_pkg;

    // Field geometry of the activation sequence
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 3;
    localparam int SEQ_LEN    = FIELD_W * NUM_FIELDS;
    localparam int CNT_W      = $clog2(SEQ_LEN + 1);

    // Supported field values (each sent bit 0 first)
    localparam logic [FIELD_W-1:0] ACT_STAR2   = 4'b1100;
    localparam logic [FIELD_W-1:0] EXT_SHORT   = 4'b1000;
    localparam logic [FIELD_W-1:0] CHECK_ZERO  = 4'b0000;

    typedef enum logic [1:0] {
        LINK_OFFLINE = 2'd0,
        LINK_COLLECT = 2'd1,
        LINK_ONLINE  = 2'd2
    } link_state_e;

    typedef struct packed {
        logic [SEQ_LEN-1:0] word;
        logic [CNT_W-1:0]   count;
    } capture_t;

    // First-sent field ends up in the low bits of the collected word
    function automatic logic [SEQ_LEN-1:0] pack_fields(
        input logic [FIELD_W-1:0] act_f,
        input logic [FIELD_W-1:0] ext_f,
        input logic [FIELD_W-1:0] chk_f
    );
        return {chk_f, ext_f, act_f};
    endfunction

    // Newest bit enters at the top, so the first bit lands at bit 0
    function automatic logic [SEQ_LEN-1:0] shift_bit(
        input logic [SEQ_LEN-1:0] word,
        input logic               bit_in
    );
        return {bit_in, word[SEQ_LEN-1:1]};
    endfunction

    localparam logic [SEQ_LEN-1:0] DEFAULT_PATTERN =
        pack_fields(ACT_STAR2, EXT_SHORT, CHECK_ZERO);

endpackage

// File: rtl/oac_capture.sv
module oac_capture
    import oac_pkg::*;
#(
    parameter int LEN   = SEQ_LEN,
    parameter int CW    = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           take,
    input  logic           bit_in,
    output logic [LEN-1:0] word_next,
    output logic           last_bit
);

    localparam logic [CW-1:0] LAST_IDX = CW'(LEN - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [LEN-1:0] word_q;
    logic [CW-1:0]  count_q;

    // Word as it will be once the current bit is taken
    assign word_next = {bit_in, word_q[LEN-1:1]};
    assign last_bit  = take && (count_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word_q  <= '0;
            count_q <= '0;
        end else if (take) begin
            word_q  <= word_next;
            count_q <= count_q + ONE;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(LEN)); // R3

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count_q == '0)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!take && !clear) |=> $stable(count_q)); // R3

endmodule

// File: rtl/oac_match.sv
module oac_match #(
    parameter int                     FW      = 4,
    parameter int                     NF      = 3,
    parameter logic [FW*NF-1:0]       EXPECT  = '0
) (
    input  logic [FW*NF-1:0] word,
    output logic             all_ok
);

    logic [NF-1:0] field_ok;

    // One comparator per field
    for (genvar f = 0; f < NF; f++) begin : g_field
        assign field_ok[f] = (word[f*FW +: FW] == EXPECT[f*FW +: FW]);
    end

    assign all_ok = &field_ok;

endmodule

// File: rtl/oac_link_fsm.sv
module oac_link_fsm
    import oac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cancel,
    input  logic        last_bit,
    input  logic        all_ok,
    output logic        collecting,
    output logic        clear_cap,
    output logic        active,
    output logic        abort
);

    link_state_e state_q, state_n;
    logic        abort_n, abort_q;

    always_comb begin
        state_n   = state_q;
        abort_n   = 1'b0;
        clear_cap = 1'b0;
        unique case (state_q)
            LINK_OFFLINE: begin
                if (start) begin
                    state_n   = LINK_COLLECT;
                    clear_cap = 1'b1;
                end
            end
            LINK_COLLECT: begin
                if (cancel) begin
                    state_n   = LINK_OFFLINE;
                    abort_n   = 1'b1;
                    clear_cap = 1'b1;
                end else if (start) begin
                    state_n   = LINK_COLLECT;
                    clear_cap = 1'b1;
                end else if (last_bit) begin
                    if (all_ok) begin
                        state_n = LINK_ONLINE;
                    end else begin
                        state_n = LINK_OFFLINE;
                        abort_n = 1'b1;
                    end
                end
            end
            LINK_ONLINE: begin
                if (cancel) state_n = LINK_OFFLINE;
            end
            default: state_n = LINK_OFFLINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINK_OFFLINE;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_n;
            abort_q <= abort_n;
        end
    end

    assign collecting = (state_q == LINK_COLLECT);
    assign active     = (state_q == LINK_ONLINE);
    assign abort      = abort_q;

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort); // R6

    AST_ABORT_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        abort |-> !active); // R6

    AST_ACTIVE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(last_bit)); // R5

    AST_OFFLINE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINK_OFFLINE && !start) |=> (state_q == LINK_OFFLINE)); // R2

    AST_ONLINE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (active && !cancel) |=> active); // R9

    AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !active); // R10

endmodule

// File: rtl/online_act_checker.sv
module online_act_checker
    import oac_pkg::*;
#(
    parameter int                           FW      = FIELD_W,
    parameter int                           NF      = NUM_FIELDS,
    parameter logic [FIELD_W*NUM_FIELDS-1:0] PATTERN = DEFAULT_PATTERN
) (
    input  logic clk,
    input  logic rst,
    input  logic tck_rise,
    input  logic tms_bit,
    input  logic start,
    input  logic cancel,
    output logic active,
    output logic abort
);

    localparam int LEN = FW * NF;
    localparam int CW  = $clog2(LEN + 1);

    logic           collecting;
    logic           clear_cap;
    logic           take;
    logic           last_bit;
    logic           all_ok;
    logic [LEN-1:0] word_next;

    assign take = collecting && tck_rise;

    oac_capture #(
        .LEN (LEN),
        .CW  (CW)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear_cap),
        .take      (take),
        .bit_in    (tms_bit),
        .word_next (word_next),
        .last_bit  (last_bit)
    );

    oac_match #(
        .FW     (FW),
        .NF     (NF),
        .EXPECT (PATTERN)
    ) u_match (
        .word   (word_next),
        .all_ok (all_ok)
    );

    oac_link_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cancel     (cancel),
        .last_bit   (last_bit),
        .all_ok     (all_ok),
        .collecting (collecting),
        .clear_cap  (clear_cap),
        .active     (active),
        .abort      (abort)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!active && !abort)); // R1

endmodule

// File: tb/sim_online_act_checker.sv
module sim_online_act_checker;

    localparam logic [11:0] GOOD = {4'b0000, 4'b1000, 4'b1100};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tck_rise = 1'b0;
    logic tms_bit = 1'b0;
    logic start = 1'b0;
    logic cancel = 1'b0;
    logic active;
    logic abort;

    int n_vec = 0;
    int n_bad = 0;
    int abort_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    online_act_checker u0 (
        .clk      (clk),
        .rst      (rst),
        .tck_rise (tck_rise),
        .tms_bit  (tms_bit),
        .start    (start),
        .cancel   (cancel),
        .active   (active),
        .abort    (abort)
    );

    always @(posedge clk) if (abort) abort_cnt <= abort_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        tms_bit  = b;
        tck_rise = 1'b1;
        @(negedge clk);
        tck_rise = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_bits(input logic [11:0] bits, input int from, input int upto, input int gap);
        for (int i = from; i < upto; i++) send_bit(bits[i], gap);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_cancel();
        @(negedge clk); cancel = 1'b1;
        @(negedge clk); cancel = 1'b0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        idle(3);
        chk("R1 active in reset", active, 0);
        chk("R1 abort in reset", abort, 0);
        @(negedge clk); rst = 1'b0;
        idle(2);
        chk("R1 active after reset", active, 0);
    endtask

    task automatic t_good();
        int a0 = abort_cnt;
        pulse_start();
        send_bits(GOOD, 0, 11, 0);
        chk("R5 not active after 11 bits", active, 0);
        send_bit(GOOD[11], 0);
        chk("R4 R5 active after 12th bit", active, 1);
        idle(2);
        chk("R4 no abort on good pattern", abort_cnt - a0, 0);
    endtask

    task automatic t_online_ignore();
        int a0 = abort_cnt;
        send_bits(12'hFFF, 0, 12, 0);
        pulse_start();
        send_bits(12'h5A5, 0, 12, 1);
        chk("R9 active holds", active, 1);
        idle(2);
        chk("R9 no abort while online", abort_cnt - a0, 0);
    endtask

    task automatic t_cancel_online();
        int a0 = abort_cnt;
        pulse_cancel();
        chk("R10 cancel clears active", active, 0);
        idle(2);
        chk("R10 no abort on cancel online", abort_cnt - a0, 0);
    endtask

    task automatic t_offline_ignore();
        int a0 = abort_cnt;
        send_bits(GOOD, 0, 12, 0);
        idle(2);
        chk("R2 offline ignores bits", active, 0);
        chk("R2 no abort offline", abort_cnt - a0, 0);
    endtask

    task automatic t_bad(input int pos, input string tag);
        logic [11:0] bad = GOOD;
        int a0 = abort_cnt;
        bad[pos] = ~bad[pos];
        pulse_start();
        send_bits(bad, 0, 11, 0);
        idle(1);
        chk({tag, " no early abort"}, abort_cnt - a0, 0);
        send_bit(bad[11], 0);
        chk({tag, " not active"}, active, 0);
        idle(2);
        chk({tag, " one abort"}, abort_cnt - a0, 1);
        send_bits(GOOD, 0, 12, 0);
        chk({tag, " stays offline"}, active, 0);
    endtask

    task automatic t_gaps();
        pulse_start();
        send_bits(GOOD, 0, 11, 3);
        chk("R3 gapped 11 bits inactive", active, 0);
        send_bit(GOOD[11], 0);
        chk("R3 gapped pattern activates", active, 1);
        pulse_rst();
        chk("R10 rst clears active", active, 0);
    endtask

    task automatic t_cancel_mid();
        int a0 = abort_cnt;
        pulse_start();
        send_bits(GOOD, 0, 6, 0);
        pulse_cancel();
        idle(2);
        chk("R7 cancel mid aborts", abort_cnt - a0, 1);
        send_bits(GOOD, 6, 12, 0);
        send_bits(GOOD, 0, 6, 0);
        chk("R7 no activation after cancel", active, 0);
    endtask

    task automatic t_restart();
        int a0 = abort_cnt;
        pulse_start();
        send_bits(12'hFFF, 0, 5, 0);
        pulse_start();
        send_bits(GOOD, 0, 11, 0);
        chk("R8 restart needs 12 fresh bits", active, 0);
        send_bit(GOOD[11], 0);
        chk("R8 restart then activates", active, 1);
        idle(2);
        chk("R8 no abort on restart", abort_cnt - a0, 0);
        pulse_rst();
    endtask

    task automatic t_rst_mid();
        int a0 = abort_cnt;
        pulse_start();
        send_bits(GOOD, 0, 6, 0);
        pulse_rst();
        idle(2);
        chk("R11 no abort on reset", abort_cnt - a0, 0);
        send_bits(GOOD, 6, 12, 0);
        send_bits(GOOD, 0, 6, 0);
        chk("R11 no activation after reset", active, 0);
    endtask

    initial begin
        t_reset();
        t_good();
        t_online_ignore();
        t_cancel_online();
        t_offline_ignore();
        t_bad(2, "R6 act field");
        t_bad(11, "R6 check field");
        t_gaps();
        t_cancel_mid();
        t_restart();
        t_rst_mid();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule